// File: doc/BRIEF.md
# Low-Power DDR SDRAM Bank State Tracker

This block sits on the controller side of a low-power DDR SDRAM channel and watches the decoded command stream. It keeps a picture of the device's four banks. For each bank it records whether a row is open, and if so which row. The controller can then use that picture to choose commands, and a monitor can use it to catch protocol mistakes.

Commands that do not fit the current bank state are reported. The report is a one-cycle pulse that carries a code naming the kind of violation. A rejected command leaves the tracked state untouched. The block also follows the clock-enable input and reports the power mode: normal operation, power-down with all banks idle, power-down with a row open, or self refresh.

Timing parameters, data capture and pad signalling are not part of this block. Auto precharge is modelled by holding the bank open until the external burst-active indication drops.

Top module: `lpddr_bank_tracker`

## Requirements
- R1: Synchronous reset leaves these values on the outputs: `bank_open` = 0, `open_rows` = 0, `illegal` = 0, `illegal_code` = 0 and `power_mode` = 0. Power mode 0 means normal operation.
- R2: Command code 1 is ACTIVE. In normal mode with `cke` high, ACTIVE to an idle bank `ba` does two things on the next edge: it sets `bank_open[ba]`, and it stores `addr` in `open_rows[ba*12 +: 12]`.
- R3: Code 2 is READ and code 3 is WRITE. Either one aimed at an idle bank is illegal with code 1 and changes no state.
- R4: ACTIVE aimed at a bank that is already open is illegal with code 2. The stored row stays unchanged.
- R5: Code 4 is PRECHARGE. With `addr[10]` low it closes only bank `ba`. With `addr[10]` high it closes every bank. A closed bank reads row 0.
- R6: A READ or WRITE with `addr[10]` high marks the bank for auto precharge. The bank stays open until the first later cycle in which `burst_active` is low, and it closes on that edge. Any READ or WRITE to the bank while it waits is illegal with code 5. With `addr[10]` low the bank stays open.
- R7: A READ or WRITE to an open bank is accepted while a burst in another bank is running. The busy bank's flag and row do not change.
- R8: Code 6 is MODE LOAD, whatever the value of `ba`. It is illegal with code 3 when any bank is open or `burst_active` is high. It never changes the bank state.
- R9: Code 5 is REFRESH. With any bank open it is illegal with code 4 and is ignored. REFRESH while `cke` is low in normal mode, with all banks idle, enters self refresh (power mode 3).
- R10: In normal mode, `cke` low with any command other than REFRESH enters power-down. This is mode 1 if all banks are idle and mode 2 if any bank is open. From modes 1, 2 and 3, `cke` high returns the block to mode 0 on the next edge.
- R11: Outside normal mode, and in any cycle with `cke` low, every command is ignored. The bank state is left unchanged and no violation is raised, except for the REFRESH check in R9.
- R12: `illegal` and `illegal_code` are registered. They show a violation on the edge that samples the offending command and clear on the next edge unless a new violation arrives. Codes 0 and 7 are never reported with a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Decoded command: 0 no-op, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 MODE LOAD, 7 burst stop |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row or column address; bit 10 selects all-bank precharge or auto precharge |
| cke | input | 1 | Clock enable as sampled by the device |
| burst_active | input | 1 | High while a data burst is in progress |
| bank_open | output | 4 | One flag per bank, set while a row is open |
| open_rows | output | 48 | Open row of each bank, 12 bits per bank, bank 0 in the low bits |
| illegal | output | 1 | One-cycle violation pulse |
| illegal_code | output | 3 | Violation kind: 1 access to idle bank, 2 activate to open bank, 3 mode load while busy, 4 refresh with open row, 5 access to bank awaiting auto precharge |
| power_mode | output | 2 | 0 normal, 1 idle power-down, 2 active power-down, 3 self refresh |

## Verification
Every bank flag and row register is visible at the ports. A corrupted bank state therefore shows up on the very edge after the command that caused it. If the corruption sits in the hidden auto-precharge marker, it shows later: the bank fails to close when the burst ends, or a later access to it draws code 5 when it should not (or fails to draw it). A wrong power-mode decision appears one edge after `cke` changes. It also shows as commands that are wrongly accepted or wrongly dropped while the mode is wrong. The bench keeps its own model, derived from the requirements, and compares every output after each edge. It runs directed sequences and a long pseudo-random sweep.

// File: rtl/lpddr_bank_tracker.sv
`timescale 1ns/1ps
module lpddr_bank_tracker #(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  localparam int NB    = 1 << BA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          cmd,
  input  logic [BA_W-1:0]     ba,
  input  logic [ROW_W-1:0]    addr,
  input  logic                cke,
  input  logic                burst_active,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_rows,
  output logic                illegal,
  output logic [2:0]          illegal_code,
  output logic [1:0]          power_mode
);
  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4,
                         C_REF = 3'd5, C_MRS = 3'd6;
  localparam logic [1:0] PM_RUN = 2'd0, PM_PPD = 2'd1, PM_APD = 2'd2, PM_SREF = 2'd3;

  logic [NB-1:0]    closing;
  logic [ROW_W-1:0] row_q [NB];
  logic [2:0]       viol;

  wire live        = cke && power_mode == PM_RUN;
  wire all_idle    = ~|bank_open;
  wire tgt_open    = bank_open[ba];
  wire tgt_closing = closing[ba];
  wire ap          = addr[AP_BIT];

  for (genvar g = 0; g < NB; g++) begin : g_rows
    assign open_rows[g*ROW_W +: ROW_W] = row_q[g];
  end

  always_comb begin
    viol = 3'd0;
    if (live) begin
      case (cmd)
        C_ACT:      if (tgt_open) viol = 3'd2;
        C_RD, C_WR: if (!tgt_open) viol = 3'd1;
                    else if (tgt_closing) viol = 3'd5;
        C_MRS:      if (!all_idle || burst_active) viol = 3'd3;
        C_REF:      if (!all_idle) viol = 3'd4;
        default:    ;
      endcase
    end else if (power_mode == PM_RUN && cmd == C_REF && !all_idle) begin
      viol = 3'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open    <= '0;
      closing      <= '0;
      illegal      <= 1'b0;
      illegal_code <= 3'd0;
      power_mode   <= PM_RUN;
      for (int b = 0; b < NB; b++) row_q[b] <= '0;
    end else begin
      illegal      <= viol != 3'd0;
      illegal_code <= viol;
      for (int b = 0; b < NB; b++)
        if (closing[b] && !burst_active) begin
          bank_open[b] <= 1'b0;
          closing[b]   <= 1'b0;
          row_q[b]     <= '0;
        end
      if (live && viol == 3'd0) begin
        case (cmd)
          C_ACT: begin
            bank_open[ba] <= 1'b1;
            row_q[ba]     <= addr;
          end
          C_RD, C_WR: if (ap) closing[ba] <= 1'b1;
          C_PRE:
            for (int b = 0; b < NB; b++)
              if (ap || ba == BA_W'(b)) begin
                bank_open[b] <= 1'b0;
                closing[b]   <= 1'b0;
                row_q[b]     <= '0;
              end
          default: ;
        endcase
      end
      if (power_mode == PM_RUN) begin
        if (!cke)
          power_mode <= (cmd == C_REF && all_idle) ? PM_SREF : (all_idle ? PM_PPD : PM_APD);
      end else if (cke) begin
        power_mode <= PM_RUN;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (bank_open == '0 && open_rows == '0 && power_mode == PM_RUN && !illegal));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
    live && cmd == C_ACT && !tgt_open |=>
      bank_open[$past(ba)] && open_rows[$past(ba)*ROW_W +: ROW_W] == $past(addr));

  assert_act_keeps_row_R4: assert property (@(posedge clk) disable iff (rst)
    live && cmd == C_ACT && tgt_open && burst_active |=> $stable(open_rows) && illegal_code == 3'd2);

  assert_mode_load_busy_R8: assert property (@(posedge clk) disable iff (rst)
    live && cmd == C_MRS && burst_active |=> illegal && illegal_code == 3'd3 && $stable(bank_open));

  assert_sref_needs_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(power_mode == PM_SREF) |-> $past(all_idle));

  assert_pd_kind_R10: assert property (@(posedge clk) disable iff (rst)
    power_mode == PM_RUN && !cke && cmd != C_REF |=>
      power_mode == ($past(all_idle) ? PM_PPD : PM_APD));

  assert_sref_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    power_mode == PM_SREF |=> $stable(bank_open) && $stable(open_rows));

  assert_code_valid_R12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> illegal_code != 3'd0 && illegal_code != 3'd7);
endmodule

// File: tb/test_lpddr_bank_tracker.sv
`timescale 1ns/1ps
module test_lpddr_bank_tracker;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] ba = 2'd0;
  logic [11:0] addr = 12'd0;
  logic cke = 1'b1, burst = 1'b0;
  logic [3:0] bank_open;
  logic [47:0] open_rows;
  logic illegal;
  logic [2:0] illegal_code;
  logic [1:0] power_mode;

  int checks = 0, fails = 0;
  bit m_open[4], m_clo[4];
  logic [11:0] m_row[4];
  logic [1:0] m_pm = 2'd0;
  logic [2:0] m_code = 3'd0;

  always #2.5 clk = ~clk;

  lpddr_bank_tracker i_lpddr_bank_tracker (
    .clk(clk), .rst(rst), .cmd(cmd), .ba(ba), .addr(addr), .cke(cke),
    .burst_active(burst), .bank_open(bank_open), .open_rows(open_rows),
    .illegal(illegal), .illegal_code(illegal_code), .power_mode(power_mode));

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic [2:0] c, input logic [1:0] b, input logic [11:0] a,
                     input logic k, input logic bu, input string tag);
    bit live, idle;
    logic [2:0] v;
    logic [3:0] op;
    logic [47:0] rows;
    @(negedge clk);
    rst = r; cmd = c; ba = b; addr = a; cke = k; burst = bu;
    if (r) begin
      for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_clo[i] = 0; m_row[i] = 0; end
      m_pm = 0; m_code = 0;
    end else begin
      idle = 1;
      for (int i = 0; i < 4; i++) if (m_open[i]) idle = 0;
      live = k && m_pm == 0;
      v = 0;
      if (live) begin
        case (c)
          3'd1: if (m_open[b]) v = 2;
          3'd2, 3'd3: if (!m_open[b]) v = 1; else if (m_clo[b]) v = 5;
          3'd6: if (!idle || bu) v = 3;
          3'd5: if (!idle) v = 4;
          default: ;
        endcase
      end else if (m_pm == 0 && c == 3'd5 && !idle) v = 4;
      m_code = v;
      for (int i = 0; i < 4; i++)
        if (m_clo[i] && !bu) begin m_open[i] = 0; m_clo[i] = 0; m_row[i] = 0; end
      if (live && v == 0) begin
        case (c)
          3'd1: begin m_open[b] = 1; m_row[b] = a; end
          3'd2, 3'd3: if (a[10]) m_clo[b] = 1;
          3'd4: for (int i = 0; i < 4; i++)
                  if (a[10] || i == int'(b)) begin m_open[i] = 0; m_clo[i] = 0; m_row[i] = 0; end
          default: ;
        endcase
      end
      if (m_pm == 0) begin
        if (!k) m_pm = (c == 3'd5 && idle) ? 2'd3 : (idle ? 2'd1 : 2'd2);
      end else if (k) m_pm = 0;
    end
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) begin op[i] = m_open[i]; rows[i*12 +: 12] = m_row[i]; end
    chk(tag, "bank_open", 64'(bank_open), 64'(op));
    chk(tag, "open_rows", 64'(open_rows), 64'(rows));
    chk(tag, "illegal", 64'(illegal), 64'(m_code != 0));
    chk(tag, "illegal_code", 64'(illegal_code), 64'(m_code));
    chk(tag, "power_mode", 64'(power_mode), 64'(m_pm));
  endtask

  task automatic nop(input string tag);
    cyc(0, 3'd0, 2'd0, 12'd0, 1, 0, tag);
  endtask

  initial begin
    logic [31:0] s = 32'h1234_5678;
    cyc(1, 0, 0, 0, 1, 0, "R1 reset");
    cyc(1, 0, 0, 0, 1, 0, "R1 reset");
    nop("R1 idle after reset");
    for (int b = 0; b < 4; b++) cyc(0, 3'd1, 2'(b), 12'(12'hA51 + b * 12'h111), 1, 0, "R2 activate");
    cyc(0, 3'd1, 2'd1, 12'h777, 1, 0, "R4 activate open bank");
    nop("R12 pulse clears");
    cyc(0, 3'd2, 2'd0, 12'h010, 1, 0, "R6 read no auto precharge");
    cyc(0, 3'd4, 2'd2, 12'h000, 1, 0, "R5 single-bank precharge");
    cyc(0, 3'd2, 2'd2, 12'h000, 1, 0, "R3 read idle bank");
    cyc(0, 3'd3, 2'd2, 12'h000, 1, 0, "R3 write idle bank");
    cyc(0, 3'd6, 2'd0, 12'h000, 1, 0, "R8 mode load with open rows");
    cyc(0, 3'd3, 2'd3, 12'h400, 1, 1, "R6 write with auto precharge");
    cyc(0, 3'd2, 2'd0, 12'h000, 1, 1, "R7 read other bank during burst");
    cyc(0, 3'd2, 2'd3, 12'h000, 1, 1, "R6 access to closing bank");
    cyc(0, 3'd1, 2'd3, 12'h123, 1, 1, "R4 activate closing bank");
    nop("R6 close on burst end");
    nop("R6 stays closed");
    cyc(0, 3'd0, 2'd0, 12'h000, 0, 0, "R10 active power-down");
    cyc(0, 3'd4, 2'd0, 12'h400, 0, 0, "R11 precharge ignored in power-down");
    cyc(0, 3'd2, 2'd2, 12'h000, 1, 0, "R11 ignored on exit cycle");
    cyc(0, 3'd5, 2'd0, 12'h000, 0, 0, "R9 refresh with open rows");
    nop("R10 return to normal");
    cyc(0, 3'd4, 2'd1, 12'h400, 1, 0, "R5 all-bank precharge");
    cyc(0, 3'd6, 2'd0, 12'h000, 1, 1, "R8 mode load during burst");
    cyc(0, 3'd6, 2'd1, 12'h000, 1, 0, "R8 mode load legal");
    cyc(0, 3'd5, 2'd0, 12'h000, 0, 0, "R9 self refresh entry");
    cyc(0, 3'd1, 2'd2, 12'h0F0, 0, 0, "R11 activate ignored in self refresh");
    cyc(0, 3'd1, 2'd2, 12'h0F0, 1, 0, "R11 self refresh exit");
    nop("R10 normal");
    cyc(0, 3'd0, 2'd0, 12'h000, 0, 0, "R10 precharge power-down");
    nop("R10 exit");
    for (int n = 0; n < 4000; n++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      cyc(0, s[2:0], s[4:3], s[16:5], s[21:18] != 4'd0, s[22], "R12 sweep");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule